// File: doc/BRIEF.md
# Prescaled Interval Timer with Watchdog and Wake Delay

This block is a free-running binary counter that advances once per main-clock tick, where a tick is produced by dividing the fast clock by `PRESCALE` (8 by default). Software sees the counter through a four-bit readout of high-order taps. The taps are bits 12 to 15 with the default 17-bit counter. A mode write picks the readout format and switches the watchdog on. A clear strobe zeroes the counter. If the counter reaches its top bit while the watchdog is enabled, the block emits a one-cycle reset request.

The same counter times the oscillator settling wait. It does this once after reset and again after the chip leaves its low-power hold state. A four-state machine controls it:

- **SETTLE**: entered from reset. Takes the `settle_done` transition into **RUN** when the top bit sets.
- **RUN**: takes `hold_enter` into **HOLD** when `hold_req` is high. Takes `wdog_trip` or `silent_wrap` back into RUN when the top bit sets.
- **HOLD**: the counter is frozen. Takes `wake_seen` into **REWAKE** when `wake_in` is high.
- **REWAKE**: takes `rewake_done` into **RUN** when the top bit sets.

`ready` is high only in RUN.

Top module: `wake_wdog_timer`

## Requirements
- R1: After reset, `rd_nibble` = 0, `ready` = 0 and `wdog_rst` = 0. The mode register is 0, so the readout shows only the top tap and the watchdog is off.
- R2: The counter advances by one every `PRESCALE` clock cycles and holds its value between ticks. The top bit (`CNT_W-1`) therefore sets 2^(CNT_W-1)·PRESCALE cycles after a clear.
- R3: `rd_nibble` maps to the counter taps `CNT_W-1-TAP_N` to `CNT_W-2`, with the highest tap in bit 3. With mode bit 3 = 1 all four taps are shown. With mode bit 3 = 0 only bit 3 carries the highest tap, and bits 2..0 read 0.
- R4: `mode_we` loads all four bits of `mode_wdata`. Bit 0 enables the watchdog. Bits 2..1 have no effect on the readout or the watchdog.
- R5: `clr_stb` zeroes the counter on the next edge. If it coincides with a tick, the clear wins.
- R6: After reset the block stays in SETTLE with `ready` = 0 until the top bit sets. It then enters RUN, the counter restarts at 0 and `ready` goes to 1.
- R7: In RUN with the watchdog enabled, the top bit setting produces exactly one `wdog_rst` pulse of one cycle, and the counter restarts at 0. Clears issued more often than the overflow period prevent any pulse.
- R8: In RUN with the watchdog disabled, the top bit setting restarts the counter at 0 with no pulse.
- R9: `hold_req` in RUN enters HOLD. In HOLD the counter is frozen, `ready` = 0 and no pulse is produced.
- R10: `wake_in` high in HOLD enters REWAKE and clears the counter. `ready` stays 0 until the top bit sets, then RUN resumes. No watchdog pulse is produced during REWAKE.
- R11: `wake_in` outside HOLD and `hold_req` outside RUN have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 4 | Mode value (bit 3 full readout, bit 0 watchdog enable) |
| clr_stb | input | 1 | Counter clear strobe |
| hold_req | input | 1 | Request to enter the hold state |
| wake_in | input | 1 | Wake level that ends the hold state |
| rd_nibble | output | 4 | Counter tap readout |
| wdog_rst | output | 1 | One-cycle watchdog reset request |
| ready | output | 1 | Clock stable, block in RUN |

## Verification
Two functions can act in the same cycle: the clear strobe and the counter's own advance or overflow restart. The bench holds `clr_stb` high across many tick cycles and across a full overflow period with the watchdog armed. It then checks that the readout stays at zero and that no reset request appears. A second case re-arms the watchdog by clearing just before the overflow would fall. The bench judges the results against windows computed from the tick period, taking 20 cycles on either side of the predicted edge.

// File: rtl/wwt_pkg.sv
package wwt_pkg;
    typedef enum logic [1:0] {
        ST_SETTLE = 2'd0,
        ST_RUN    = 2'd1,
        ST_HOLD   = 2'd2,
        ST_REWAKE = 2'd3
    } wwt_state_e;

    localparam int MODE_FULL_BIT = 3;
    localparam int MODE_WDEN_BIT = 0;
endpackage

// File: rtl/wwt_prescale.sv
module wwt_prescale #(
    parameter int PRESCALE = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (PRESCALE <= 1) begin : g_direct
            logic tick_q;
            always_ff @(posedge clk) begin
                if (!rst_n) tick_q <= 1'b0;
                else        tick_q <= 1'b1;
            end
            assign tick = tick_q;
        end else begin : g_div
            localparam int PRE_W = $clog2(PRESCALE);
            localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
            logic [PRE_W-1:0] pre_q;
            always_ff @(posedge clk) begin
                if (!rst_n)                pre_q <= '0;
                else if (pre_q == PRE_LAST) pre_q <= '0;
                else                       pre_q <= pre_q + PRE_W'(1);
            end
            assign tick = (pre_q == PRE_LAST);
        end
    endgenerate
endmodule

// File: rtl/wwt_counter.sv
module wwt_counter #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run_en,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n)              count <= '0;
        else if (clr)            count <= '0;
        else if (tick && run_en) count <= count + CNT_W'(1);
    end

    // R5
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));

    // R9
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !clr) |=> $stable(count));

    // R2
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(count));
endmodule

// File: rtl/wwt_readout.sv
module wwt_readout #(
    parameter int TAP_N = 4
) (
    input  logic [TAP_N-1:0] taps,
    input  logic             full,
    output logic [TAP_N-1:0] nib
);
    for (genvar i = 0; i < TAP_N; i++) begin : g_tap
        if (i == TAP_N - 1) begin : g_top
            assign nib[i] = taps[i];
        end else begin : g_low
            assign nib[i] = taps[i] & full;
        end
    end
endmodule

// File: rtl/wake_wdog_timer.sv
module wake_wdog_timer
    import wwt_pkg::*;
#(
    parameter int PRESCALE = 8,
    parameter int CNT_W    = 17,
    parameter int TAP_N    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_we,
    input  logic [3:0]       mode_wdata,
    input  logic             clr_stb,
    input  logic             hold_req,
    input  logic             wake_in,
    output logic [TAP_N-1:0] rd_nibble,
    output logic             wdog_rst,
    output logic             ready
);
    localparam int TOP_BIT = CNT_W - 1;
    localparam int TAP_LO  = TOP_BIT - TAP_N;

    wwt_state_e       state, nxt;
    logic [3:0]       mode_q;
    logic [CNT_W-1:0] cnt;
    logic             tick;
    logic             cnt_top;
    logic             fsm_clr;
    logic             run_en;

    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= 4'd0;
        else if (mode_we) mode_q <= mode_wdata;
    end

    wwt_prescale #(.PRESCALE(PRESCALE)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    wwt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .run_en (run_en),
        .clr    (clr_stb | fsm_clr),
        .count  (cnt)
    );

    wwt_readout #(.TAP_N(TAP_N)) u_rd (
        .taps (cnt[TAP_LO +: TAP_N]),
        .full (mode_q[MODE_FULL_BIT]),
        .nib  (rd_nibble)
    );

    assign cnt_top = cnt[TOP_BIT];
    assign run_en  = (state != ST_HOLD);
    assign fsm_clr = (state == ST_HOLD) ? wake_in : cnt_top;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_SETTLE: if (cnt_top)  nxt = ST_RUN;
            ST_RUN:    if (hold_req) nxt = ST_HOLD;
            ST_HOLD:   if (wake_in)  nxt = ST_REWAKE;
            ST_REWAKE: if (cnt_top)  nxt = ST_RUN;
            default:                 nxt = ST_SETTLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_SETTLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready    <= 1'b0;
            wdog_rst <= 1'b0;
        end else begin
            ready    <= (nxt == ST_RUN);
            wdog_rst <= (state == ST_RUN) && cnt_top && mode_q[MODE_WDEN_BIT];
        end
    end

    // R7
    wdog_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst |=> !wdog_rst);

    // R7
    wdog_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst |-> $past(state == ST_RUN && mode_q[MODE_WDEN_BIT]));

    // R9
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> (!ready && !wdog_rst));

    // R6
    ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (cnt == '0));

    // R4
    mode_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we |=> (mode_q == $past(mode_wdata)));
endmodule

// File: tb/sim_wake_wdog_timer.sv
module sim_wake_wdog_timer;
    localparam int PRESCALE = 2;
    localparam int CNT_W    = 9;
    localparam int TAP_N    = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_we = 1'b0;
    logic [3:0] mode_wdata = 4'd0;
    logic       clr_stb = 1'b0;
    logic       hold_req = 1'b0;
    logic       wake_in = 1'b0;
    logic [3:0] rd_nibble;
    logic       wdog_rst;
    logic       ready;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    int wide = 0;
    logic wd_prev = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wake_wdog_timer #(.PRESCALE(PRESCALE), .CNT_W(CNT_W), .TAP_N(TAP_N)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .clr_stb(clr_stb), .hold_req(hold_req), .wake_in(wake_in),
        .rd_nibble(rd_nibble), .wdog_rst(wdog_rst), .ready(ready)
    );

    always @(posedge clk) begin
        if (wdog_rst) pulses++;
        if (wdog_rst && wd_prev) wide++;
        wd_prev = wdog_rst;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_mode(input logic [3:0] v);
        @(negedge clk); mode_we = 1'b1; mode_wdata = v;
        @(negedge clk); mode_we = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); clr_stb = 1'b1;
        @(negedge clk); clr_stb = 1'b0;
    endtask

    task automatic t_reset();
        wait_n(3);
        chk(rd_nibble == 4'd0, "R1 nibble", rd_nibble, 0);
        chk(ready == 1'b0, "R1 ready", ready, 0);
        chk(wdog_rst == 1'b0, "R1 wdog", wdog_rst, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_settle();
        wait_n(490);
        chk(ready == 1'b0, "R2 ready early", ready, 0);
        wait_n(50);
        chk(ready == 1'b1, "R6 ready after settle", ready, 1);
        chk(rd_nibble == 4'd0, "R6 counter restarted", rd_nibble, 0);
        chk(pulses == 0, "R6 no pulse in settle", pulses, 0);
    endtask

    task automatic t_readout();
        write_mode(4'b1000);
        pulse_clr();
        wait_n(432);
        chk(rd_nibble == 4'hD, "R3 full readout", rd_nibble, 13);
        write_mode(4'b0110);
        chk(rd_nibble == 4'h8, "R3 R4 top tap only", rd_nibble, 8);
    endtask

    task automatic t_clear();
        write_mode(4'b1000);
        wait_n(20);
        pulse_clr();
        chk(rd_nibble == 4'd0, "R5 clear", rd_nibble, 0);
        write_mode(4'b1001);
        pulses = 0;
        @(negedge clk); clr_stb = 1'b1;
        wait_n(600);
        chk(rd_nibble == 4'd0, "R5 held clear", rd_nibble, 0);
        chk(pulses == 0, "R5 clear beats overflow", pulses, 0);
        clr_stb = 1'b0;
    endtask

    task automatic t_watchdog();
        write_mode(4'b1001);
        pulse_clr();
        pulses = 0; wide = 0;
        wait_n(488);
        chk(pulses == 0, "R7 no early pulse", pulses, 0);
        wait_n(50);
        chk(pulses == 1, "R7 one pulse", pulses, 1);
        chk(wide == 0, "R7 pulse width", wide, 0);
        chk(rd_nibble == 4'd0, "R7 counter restarted", rd_nibble, 0);
        pulse_clr();
        pulses = 0;
        for (int k = 0; k < 6; k++) begin
            wait_n(200);
            pulse_clr();
        end
        chk(pulses == 0, "R7 kicked watchdog", pulses, 0);
        write_mode(4'b1000);
    endtask

    task automatic t_wdog_off();
        pulse_clr();
        pulses = 0;
        wait_n(1100);
        chk(pulses == 0, "R8 disabled watchdog", pulses, 0);
        chk(ready == 1'b1, "R8 ready kept", ready, 1);
    endtask

    task automatic t_hold_wake();
        logic [3:0] seen;
        write_mode(4'b1001);
        pulse_clr();
        wait_n(336);
        seen = rd_nibble;
        chk(seen == 4'hA, "R9 pre-hold value", seen, 10);
        @(negedge clk); hold_req = 1'b1;
        @(negedge clk); hold_req = 1'b0;
        pulses = 0;
        wait_n(4);
        chk(ready == 1'b0, "R9 ready low in hold", ready, 0);
        wait_n(1200);
        chk(rd_nibble == seen, "R9 frozen", rd_nibble, seen);
        chk(pulses == 0, "R9 no pulse in hold", pulses, 0);
        @(negedge clk); wake_in = 1'b1;
        @(negedge clk); wake_in = 1'b0;
        wait_n(3);
        chk(rd_nibble == 4'd0, "R10 cleared on wake", rd_nibble, 0);
        chk(ready == 1'b0, "R10 ready low", ready, 0);
        wait_n(100);
        @(negedge clk); hold_req = 1'b1;
        @(negedge clk); hold_req = 1'b0;
        wait_n(380);
        chk(ready == 1'b0, "R10 still waiting", ready, 0);
        wait_n(50);
        chk(ready == 1'b1, "R10 R11 ready again", ready, 1);
        chk(pulses == 0, "R10 no pulse in wait", pulses, 0);
        write_mode(4'b1000);
    endtask

    task automatic t_ignored();
        pulse_clr();
        wait_n(208);
        chk(rd_nibble == 4'h6, "R11 pre value", rd_nibble, 6);
        @(negedge clk); wake_in = 1'b1;
        @(negedge clk); wake_in = 1'b0;
        wait_n(4);
        chk(rd_nibble == 4'h6, "R11 wake ignored in run", rd_nibble, 6);
        chk(ready == 1'b1, "R11 ready kept", ready, 1);
    endtask

    initial begin
        t_reset();
        t_settle();
        t_readout();
        t_clear();
        t_watchdog();
        t_wdog_off();
        t_hold_wake();
        t_ignored();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule